// File: doc/BRIEF.md
# SPI Controller Status Flag Register

This block holds the status word of a queued SPI controller. The transfer engine and the FIFOs send it pulses and levels: the final receive bit of a frame has been sampled, the running command carries an end-of-queue marker, the controller is a slave, TX FIFO empty and full, RX FIFO plus receive shift register full, a transfer is starting, and a DMA acknowledge. The block turns these into sticky event flags and a run/stop status bit.

Software reads the whole word on `rd_data`. It clears any event flag by writing a 1 to its position through `wr_en`/`wr_data`. The shift engine, the FIFOs, the delay timers and interrupt routing sit outside the block. The block only keeps the flag state. Every flag is a flop, so each input event shows on `rd_data` after exactly one rising clock edge.

Top module: `spi_stat_reg`

## Requirements
- R1: The transfer-done flag (bit 0) is 1 in the cycle after the edge at which `last_bit_smp` was high.
- R2: The event flags (bits 0, 3, 4, 6, 12) are cleared by a write (`wr_en`=1) with a 1 in their position. A 0 in the written word leaves a flag unchanged. If a set condition and a write-1 clear hit the same flag at one edge, the flag ends up 1.
- R3: The end-of-queue flag (bit 3) sets only at an edge where `last_bit_smp`=1, `cmd_eoq_bit`=1 and `slave_mode`=0. It never sets in slave mode.
- R4: The run bit (bit 1) becomes 1 after an edge with `run_req`. It becomes 0 after an edge with `stop_req` or with an end-of-queue event as defined in R3. A clear wins over `run_req` at the same edge. Writes never change bit 1.
- R5: The TX underflow flag (bit 4) sets at an edge where `slave_mode`, `xfer_begin` and `txq_empty` are all 1. It never sets in master mode.
- R6: The TX fill-request flag (bit 6) is 1 after every edge at which `txq_full`=0. At an edge with `txq_full`=1, it is cleared by a write-1 or by `dma_fill_ack`=1. Otherwise it holds.
- R7: The RX overflow flag (bit 12) sets at an edge where `xfer_begin`=1 and `rxq_all_full`=1.
- R8: Bits 2, 5, 7 to 11 and 13 to 15 always read 0, whatever is written. A synchronous active-high `rst` brings the whole word to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| last_bit_smp | input | 1 | Pulse: final receive bit of the frame has been sampled |
| cmd_eoq_bit | input | 1 | Level: the running command carries the end-of-queue marker |
| slave_mode | input | 1 | Level: 1 when the controller runs as a slave |
| txq_empty | input | 1 | Level: TX FIFO is empty |
| txq_full | input | 1 | Level: TX FIFO is full |
| rxq_all_full | input | 1 | Level: RX FIFO and receive shift register are both full |
| xfer_begin | input | 1 | Pulse: a transfer is starting |
| dma_fill_ack | input | 1 | Pulse: DMA acknowledge of a fill request |
| run_req | input | 1 | Pulse: enter running state |
| stop_req | input | 1 | Pulse: enter stopped state |
| wr_en | input | 1 | Write strobe for the status word |
| wr_data | input | 16 | Written word; a 1 clears the matching event flag |
| rd_data | output | 16 | Current status word |

## Verification
Every result is due one rising edge after the inputs that cause it. This holds for sets, write-1 clears, the run bit and the reset. The bench changes the inputs on the falling edge and advances its reference word on the next rising edge. It then compares the whole `rd_data` word on the following falling edge, so every comparison falls in the single cycle where the result is due. The directed steps cover the same-edge races: a set against a clear, a stop or end-of-queue against a start, and a DMA acknowledge while the FIFO is full or not full. They run before a long seeded random run.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

  localparam int unsigned STAT_W = 16;

  localparam int unsigned B_DONE = 0;
  localparam int unsigned B_RUN  = 1;
  localparam int unsigned B_EOQ  = 3;
  localparam int unsigned B_UFL  = 4;
  localparam int unsigned B_FILL = 6;
  localparam int unsigned B_OVF  = 12;

  localparam logic [STAT_W-1:0] W1C_MASK =
    STAT_W'((1 << B_DONE) | (1 << B_EOQ) | (1 << B_UFL) | (1 << B_FILL) | (1 << B_OVF));
  localparam logic [STAT_W-1:0] LIVE_MASK = W1C_MASK | STAT_W'(1 << B_RUN);

endpackage

// File: rtl/spi_stat_evt.sv
module spi_stat_evt
  import spi_stat_pkg::*;
#(
  parameter int unsigned W = STAT_W
) (
  input  logic         last_bit_smp,
  input  logic         cmd_eoq_bit,
  input  logic         slave_mode,
  input  logic         txq_empty,
  input  logic         txq_full,
  input  logic         rxq_all_full,
  input  logic         xfer_begin,
  input  logic         dma_fill_ack,
  output logic [W-1:0] set_vec,
  output logic [W-1:0] hw_clr_vec,
  output logic         eoq_evt
);

  always_comb begin
    eoq_evt    = last_bit_smp & cmd_eoq_bit & ~slave_mode;
    set_vec    = '0;
    hw_clr_vec = '0;
    set_vec[B_DONE]    = last_bit_smp;
    set_vec[B_EOQ]     = eoq_evt;
    set_vec[B_UFL]     = slave_mode & xfer_begin & txq_empty;
    set_vec[B_FILL]    = ~txq_full;
    set_vec[B_OVF]     = xfer_begin & rxq_all_full;
    hw_clr_vec[B_FILL] = dma_fill_ack & txq_full;
  end

endmodule

// File: rtl/spi_stat_w1c_bank.sv
module spi_stat_w1c_bank #(
  parameter int unsigned   W    = 16,
  parameter logic [W-1:0] MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] hw_clr_vec,
  output logic [W-1:0] flags
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_flop
      logic q;
      logic sw_clr;
      assign sw_clr = wr_en & wr_data[i];
      always_ff @(posedge clk) begin
        if (rst)             q <= 1'b0;
        else if (set_vec[i]) q <= 1'b1;
        else if (sw_clr || hw_clr_vec[i]) q <= 1'b0;
      end
      assign flags[i] = q;
    end else begin : g_zero
      assign flags[i] = 1'b0;
    end
  end

endmodule

// File: rtl/spi_stat_run.sv
module spi_stat_run (
  input  logic clk,
  input  logic rst,
  input  logic run_req,
  input  logic stop_req,
  input  logic eoq_evt,
  output logic running
);

  always_ff @(posedge clk) begin
    if (rst)                      running <= 1'b0;
    else if (stop_req || eoq_evt) running <= 1'b0;
    else if (run_req)             running <= 1'b1;
  end

endmodule

// File: rtl/spi_stat_reg.sv
module spi_stat_reg
  import spi_stat_pkg::*;
#(
  parameter int unsigned W = STAT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         last_bit_smp,
  input  logic         cmd_eoq_bit,
  input  logic         slave_mode,
  input  logic         txq_empty,
  input  logic         txq_full,
  input  logic         rxq_all_full,
  input  logic         xfer_begin,
  input  logic         dma_fill_ack,
  input  logic         run_req,
  input  logic         stop_req,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data
);

  localparam logic [W-1:0] FLAG_MASK = W'(W1C_MASK);

  logic [W-1:0] set_vec;
  logic [W-1:0] hw_clr_vec;
  logic [W-1:0] flags;
  logic         eoq_evt;
  logic         running;

  spi_stat_evt #(.W(W)) u_evt (
    .last_bit_smp (last_bit_smp),
    .cmd_eoq_bit  (cmd_eoq_bit),
    .slave_mode   (slave_mode),
    .txq_empty    (txq_empty),
    .txq_full     (txq_full),
    .rxq_all_full (rxq_all_full),
    .xfer_begin   (xfer_begin),
    .dma_fill_ack (dma_fill_ack),
    .set_vec      (set_vec),
    .hw_clr_vec   (hw_clr_vec),
    .eoq_evt      (eoq_evt)
  );

  spi_stat_w1c_bank #(.W(W), .MASK(FLAG_MASK)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .set_vec    (set_vec),
    .hw_clr_vec (hw_clr_vec),
    .flags      (flags)
  );

  spi_stat_run u_run (
    .clk      (clk),
    .rst      (rst),
    .run_req  (run_req),
    .stop_req (stop_req),
    .eoq_evt  (eoq_evt),
    .running  (running)
  );

  always_comb begin
    rd_data        = flags;
    rd_data[B_RUN] = running;
  end

endmodule

// File: rtl/spi_stat_chk.sv
module spi_stat_chk
  import spi_stat_pkg::*;
#(
  parameter int unsigned W = STAT_W
) (
  input logic         clk,
  input logic         rst,
  input logic         last_bit_smp,
  input logic         cmd_eoq_bit,
  input logic         slave_mode,
  input logic         txq_empty,
  input logic         txq_full,
  input logic         rxq_all_full,
  input logic         xfer_begin,
  input logic         dma_fill_ack,
  input logic         run_req,
  input logic         stop_req,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] rd_data
);

  localparam logic [W-1:0] DEAD = ~W'(LIVE_MASK);

  AST_DONE_SETS: assert property (@(posedge clk) disable iff (rst)
    last_bit_smp |=> rd_data[B_DONE]); // R1

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[B_DONE] && !last_bit_smp) |=> !rd_data[B_DONE]); // R2

  AST_EOQ_MASTER_ONLY: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_data[B_EOQ]) |-> $past(last_bit_smp && cmd_eoq_bit && !slave_mode)); // R3

  AST_EOQ_STOPS_RUN: assert property (@(posedge clk) disable iff (rst)
    (last_bit_smp && cmd_eoq_bit && !slave_mode) |=> !rd_data[B_RUN]); // R4

  AST_UFL_SLAVE_ONLY: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_data[B_UFL]) |-> $past(slave_mode && xfer_begin && txq_empty)); // R5

  AST_FILL_NOT_FULL: assert property (@(posedge clk) disable iff (rst)
    !txq_full |=> rd_data[B_FILL]); // R6

  AST_OVF_SETS: assert property (@(posedge clk) disable iff (rst)
    (xfer_begin && rxq_all_full) |=> rd_data[B_OVF]); // R7

  AST_DEAD_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_data & DEAD) == '0); // R8

endmodule

bind spi_stat_reg spi_stat_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .last_bit_smp (last_bit_smp),
  .cmd_eoq_bit  (cmd_eoq_bit),
  .slave_mode   (slave_mode),
  .txq_empty    (txq_empty),
  .txq_full     (txq_full),
  .rxq_all_full (rxq_all_full),
  .xfer_begin   (xfer_begin),
  .dma_fill_ack (dma_fill_ack),
  .run_req      (run_req),
  .stop_req     (stop_req),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .rd_data      (rd_data)
);

// File: tb/sim_spi_stat_reg.sv
`timescale 1ns/1ps
module sim_spi_stat_reg;

  localparam int W = 16;
  localparam logic [W-1:0] CLR_BITS = 16'h1059;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic last_bit_smp = 0, cmd_eoq_bit = 0, slave_mode = 0, txq_empty = 0;
  logic txq_full = 1, rxq_all_full = 0, xfer_begin = 0, dma_fill_ack = 0;
  logic run_req = 0, stop_req = 0, wr_en = 0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] exp_q = '0;

  always #2 clk = ~clk;

  spi_stat_reg u0 (.*);

  function automatic logic [W-1:0] model(logic [W-1:0] cur);
    logic [W-1:0] n = cur;
    logic eoq = last_bit_smp && cmd_eoq_bit && !slave_mode;
    if (rst) return '0;
    if (wr_en) n = n & ~(wr_data & CLR_BITS);
    if (dma_fill_ack && txq_full) n[6] = 1'b0;
    if (last_bit_smp) n[0] = 1'b1;
    if (eoq) n[3] = 1'b1;
    if (slave_mode && xfer_begin && txq_empty) n[4] = 1'b1;
    if (!txq_full) n[6] = 1'b1;
    if (xfer_begin && rxq_all_full) n[12] = 1'b1;
    if (stop_req || eoq) n[1] = 1'b0;
    else if (run_req) n[1] = 1'b1;
    return n;
  endfunction

  task automatic idle();
    last_bit_smp = 0; cmd_eoq_bit = 0; xfer_begin = 0; dma_fill_ack = 0;
    run_req = 0; stop_req = 0; wr_en = 0; wr_data = '0;
  endtask

  task automatic step(string tag);
    @(posedge clk);
    exp_q = model(exp_q);
    @(negedge clk);
    checks++;
    if (rd_data !== exp_q) begin
      fails++;
      $display("FAIL %s: rd_data=%h expected=%h", tag, rd_data, exp_q);
    end
    idle();
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4411));
    @(negedge clk);
    step("R8 reset");
    step("R8 reset held");
    rst = 0;
    step("R8 idle after reset");
    // R1 and R2
    last_bit_smp = 1; step("R1 done sets");
    wr_en = 1; wr_data = 16'h0000; step("R2 write zero keeps");
    wr_en = 1; wr_data = 16'h0001; step("R2 write one clears");
    last_bit_smp = 1; wr_en = 1; wr_data = 16'h0001; step("R2 set beats clear");
    // R3
    slave_mode = 1; last_bit_smp = 1; cmd_eoq_bit = 1; step("R3 no eoq in slave");
    slave_mode = 0; run_req = 1; step("R4 run starts");
    last_bit_smp = 1; cmd_eoq_bit = 1; step("R3 eoq sets / R4 run drops");
    run_req = 1; last_bit_smp = 1; cmd_eoq_bit = 1; step("R4 eoq beats start");
    run_req = 1; step("R4 start");
    wr_en = 1; wr_data = 16'hFFFF; step("R4 write ignored on run / R2 flags clear");
    run_req = 1; stop_req = 1; step("R4 stop beats start");
    // R5
    xfer_begin = 1; txq_empty = 1; step("R5 no underflow in master");
    slave_mode = 1; xfer_begin = 1; step("R5 underflow in slave");
    txq_empty = 0; slave_mode = 0;
    // R6
    txq_full = 0; step("R6 fill sets when not full");
    wr_en = 1; wr_data = 16'h0040; step("R6 write cannot clear while not full");
    dma_fill_ack = 1; step("R6 dma ack ignored while not full");
    txq_full = 1; step("R6 holds when full");
    dma_fill_ack = 1; step("R6 dma ack clears when full");
    // R7
    rxq_all_full = 1; step("R7 no overflow without start");
    xfer_begin = 1; step("R7 overflow sets");
    rxq_all_full = 0;
    wr_en = 1; wr_data = 16'hFFFF; step("R8 reserved stay zero");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      last_bit_smp = ($urandom % 4) == 0;
      cmd_eoq_bit  = $urandom % 2;
      slave_mode   = ($urandom % 3) == 0;
      txq_empty    = $urandom % 2;
      txq_full     = txq_empty ? 1'b0 : 1'($urandom % 2);
      rxq_all_full = $urandom % 2;
      xfer_begin   = ($urandom % 4) == 0;
      dma_fill_ack = ($urandom % 3) == 0;
      run_req      = ($urandom % 3) == 0;
      stop_req     = ($urandom % 6) == 0;
      wr_en        = ($urandom % 3) == 0;
      wr_data      = W'($urandom);
      rst          = ($urandom % 500) == 0;
      step("random R1-model");
    end
    rst = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule